// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a logical address into a physical address through a single-level page table kept in ordinary memory. The logical address is split into a high page-number field and a low offset field. The page number is first compared against a table-length register. If it lies inside the table, the unit fetches one table entry from the address formed by adding the page number to a table-base register. It then examines the entry's presence flag and access rights, and answers either with the physical address or with a fault code.

A processor presents one request at a time on a valid/ready port and receives a single-cycle response. Table entries are read through a simple request/acknowledge memory port. Software-visible state is limited to two registers: the table base, which is reloaded on each context switch, and the table length. Both are written through dedicated write strobes. The physical address is the entry's frame number placed directly above the untouched offset bits, with no arithmetic.

Top module: `page_xlate_unit`

## Requirements
- R1: The page number is the top LA_W-OFS_W bits of `req_laddr` and the offset is the low OFS_W bits. A successful translation returns `rsp_paddr` = {frame, offset}, so logical 0010 maps to 1110 when page 0 holds frame 3, and 0101 maps to 0101 when page 1 holds frame 1 (2-bit page, 2-bit offset).
- R2: An in-range request causes exactly one table read, at `mem_addr` = table base + page number. `mem_addr` stays stable while `mem_req` waits for `mem_ack`.
- R3: A page number greater than or equal to the length register yields fault code 01 and performs no memory read.
- R4: An entry whose presence bit is 0 yields fault code 10. This check takes priority over the rights check.
- R5: Rights field encodings are 00 read-only (kind 00 read allowed), 01 read-write (kinds 00 read and 01 write allowed), 10 execute-only (kind 10 fetch allowed), and 11 nothing allowed. Request kind 11 is never allowed. A disallowed kind yields fault code 11.
- R6: `rsp_valid` is a one-cycle pulse. `req_ready` is low from acceptance until after the response, so only one translation is ever in flight.
- R7: Base and length writes take effect only while `req_ready` is high and are ignored otherwise. A write is used by the next accepted request.
- R8: Whenever the fault code is not 00, `rsp_paddr` is zero.
- R9: After reset, `req_ready` is 1, `rsp_valid` and `mem_req` are 0, and the base and length registers are 0, so every request faults with code 01.
- R10: The table entry holds the frame in bits [FRAME_W-1:0], the presence bit at bit FRAME_W, and the rights field in bits [FRAME_W+2:FRAME_W+1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_laddr | input | LA_W | Logical address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | FRAME_W+OFS_W | Physical address (zero on fault) |
| rsp_fault | output | 2 | 00 none, 01 out of bounds, 10 not present, 11 rights |
| mem_req | output | 1 | Table-entry read request |
| mem_addr | output | MEM_AW | Table-entry address |
| mem_ack | input | 1 | Read data valid, ends the read |
| mem_rdata | input | FRAME_W+3 | Table entry |
| base_we | input | 1 | Write strobe for the table base |
| base_wdata | input | MEM_AW | New table base |
| len_we | input | 1 | Write strobe for the table length |
| len_wdata | input | LA_W-OFS_W+1 | New table length in entries |

## Verification
The bench builds the unit with a 4-bit logical address, a 2-bit offset, a 2-bit frame and a 4-bit memory address. With these values the four-page space and the full length range from 0 to 4 can be swept completely, including a length equal to the page count and a length of zero. The two worked translations from R1 can be checked bit for bit. Two separate tables at different bases exercise the base register, and every combination of rights code and access kind fits in a handful of entries.

// File: rtl/pxu_pkg.sv
// Shared types for the paged address translation unit.
// Assumes 2-bit kind, rights and fault encodings as listed in the brief.
package pxu_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_BOUND = 2'b01,
        FLT_ABSENT = 2'b10,
        FLT_PROT  = 2'b11
    } pxu_fault_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_RSVD  = 2'b11
    } pxu_kind_e;

    typedef enum logic [1:0] {
        RGT_RDONLY = 2'b00,
        RGT_RDWR   = 2'b01,
        RGT_EXONLY = 2'b10,
        RGT_NONE   = 2'b11
    } pxu_rights_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WALK = 2'b01,
        ST_RESP = 2'b10
    } pxu_state_e;

    // Returns 1 when the rights code permits the access kind.
    function automatic logic rights_allow(input logic [1:0] rgt, input logic [1:0] kind);
        logic ok;
        ok = 1'b0;
        case (rgt)
            RGT_RDONLY: ok = (kind == KIND_READ);
            RGT_RDWR:   ok = (kind == KIND_READ) || (kind == KIND_WRITE);
            RGT_EXONLY: ok = (kind == KIND_FETCH);
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pxu_cfg_regs.sv
// Table base and table length registers.
// Writes land only when the unit reports idle; both registers reset to zero.
module pxu_cfg_regs #(
    parameter int MEM_AW = 16,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              base_we,
    input  logic [MEM_AW-1:0] base_wdata,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_wdata,
    output logic [MEM_AW-1:0] base_q,
    output logic [LEN_W-1:0]  len_q
);

    // Base register: reloaded on context switch, gated by idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_we && idle) begin
            base_q <= base_wdata;
        end
    end

    // Length register: number of valid table entries, gated by idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (len_we && idle) begin
            len_q <= len_wdata;
        end
    end

endmodule

// File: rtl/pxu_index_calc.sv
// Bound check of the page number and address of its table entry.
// Purely combinational; assumes MEM_AW >= PN_W.
module pxu_index_calc #(
    parameter int PN_W   = 6,
    parameter int MEM_AW = 16,
    localparam int LEN_W = PN_W + 1
) (
    input  logic [PN_W-1:0]   page,
    input  logic [LEN_W-1:0]  len,
    input  logic [MEM_AW-1:0] base,
    output logic              out_of_range,
    output logic [MEM_AW-1:0] ent_addr
);

    // Page must lie strictly below the table length.
    always_comb begin
        out_of_range = ({1'b0, page} >= len);
    end

    // Entry address is base plus page index, one word per entry.
    always_comb begin
        ent_addr = base + MEM_AW'(page);
    end

endmodule

// File: rtl/pxu_entry_eval.sv
// Decodes a fetched table entry and forms the response.
// Entry layout: frame low, presence bit above, rights field on top.
// Presence is checked before rights.
module pxu_entry_eval
    import pxu_pkg::*;
#(
    parameter int FRAME_W = 6,
    parameter int OFS_W   = 10,
    localparam int ENT_W  = FRAME_W + 3,
    localparam int PA_W   = FRAME_W + OFS_W
) (
    input  logic [ENT_W-1:0] entry,
    input  logic [1:0]       kind,
    input  logic [OFS_W-1:0] offset,
    output logic [1:0]       fault,
    output logic [PA_W-1:0]  paddr
);

    logic [FRAME_W-1:0] frame;
    logic               present;
    logic [1:0]         rights;

    // Field extraction according to the entry layout.
    always_comb begin
        frame   = entry[FRAME_W-1:0];
        present = entry[FRAME_W];
        rights  = entry[FRAME_W+2:FRAME_W+1];
    end

    // Ordered checks: presence first, then rights.
    always_comb begin
        if (!present) begin
            fault = FLT_ABSENT;
        end else if (!rights_allow(rights, kind)) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
    end

    // Physical address is frame above offset, zero on any fault.
    always_comb begin
        paddr = (fault == FLT_NONE) ? {frame, offset} : '0;
    end

endmodule

// File: rtl/page_xlate_unit.sv
// Single-level paged address translation.
// Accepts one request at a time and checks the bound at acceptance. For an
// in-range page it reads one entry, then evaluates it and presents the
// response for one cycle. The memory port holds its request until mem_ack.
module page_xlate_unit
    import pxu_pkg::*;
#(
    parameter int LA_W    = 16,
    parameter int OFS_W   = 10,
    parameter int FRAME_W = 8,
    parameter int MEM_AW  = 16,
    localparam int PN_W   = LA_W - OFS_W,
    localparam int LEN_W  = PN_W + 1,
    localparam int ENT_W  = FRAME_W + 3,
    localparam int PA_W   = FRAME_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LA_W-1:0]   req_laddr,
    input  logic [1:0]        req_kind,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [ENT_W-1:0]  mem_rdata,
    input  logic              base_we,
    input  logic [MEM_AW-1:0] base_wdata,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_wdata
);

    pxu_state_e         state_q;
    logic [MEM_AW-1:0]  base_q;
    logic [LEN_W-1:0]   len_q;
    logic [MEM_AW-1:0]  addr_q;
    logic [1:0]         kind_q;
    logic [OFS_W-1:0]   ofs_q;
    logic [1:0]         fault_q;
    logic [PA_W-1:0]    paddr_q;
    logic               idle;
    logic               accept;
    logic               oor;
    logic [MEM_AW-1:0]  ent_addr;
    logic [1:0]         ev_fault;
    logic [PA_W-1:0]    ev_paddr;
    logic [PN_W-1:0]    page_in;

    // Handshake decode from the current state.
    always_comb begin
        idle    = (state_q == ST_IDLE);
        accept  = idle && req_valid;
        page_in = req_laddr[LA_W-1:OFS_W];
    end

    pxu_cfg_regs #(
        .MEM_AW (MEM_AW),
        .LEN_W  (LEN_W)
    ) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (idle),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .len_we     (len_we),
        .len_wdata  (len_wdata),
        .base_q     (base_q),
        .len_q      (len_q)
    );

    pxu_index_calc #(
        .PN_W   (PN_W),
        .MEM_AW (MEM_AW)
    ) i_idx (
        .page         (page_in),
        .len          (len_q),
        .base         (base_q),
        .out_of_range (oor),
        .ent_addr     (ent_addr)
    );

    pxu_entry_eval #(
        .FRAME_W (FRAME_W),
        .OFS_W   (OFS_W)
    ) i_eval (
        .entry  (mem_rdata),
        .kind   (kind_q),
        .offset (ofs_q),
        .fault  (ev_fault),
        .paddr  (ev_paddr)
    );

    // Control sequence: idle -> (walk) -> respond -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) state_q <= oor ? ST_RESP : ST_WALK;
                ST_WALK: if (mem_ack) state_q <= ST_RESP;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request capture: entry address, kind and offset held for the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            kind_q <= '0;
            ofs_q  <= '0;
        end else if (accept && !oor) begin
            addr_q <= ent_addr;
            kind_q <= req_kind;
            ofs_q  <= req_laddr[OFS_W-1:0];
        end
    end

    // Result capture: bound fault at acceptance, entry result at read end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= FLT_NONE;
            paddr_q <= '0;
        end else if (accept && oor) begin
            fault_q <= FLT_BOUND;
            paddr_q <= '0;
        end else if (state_q == ST_WALK && mem_ack) begin
            fault_q <= ev_fault;
            paddr_q <= ev_paddr;
        end
    end

    // Port outputs decoded from state and captured results.
    always_comb begin
        req_ready = idle;
        mem_req   = (state_q == ST_WALK);
        mem_addr  = addr_q;
        rsp_valid = (state_q == ST_RESP);
        rsp_fault = fault_q;
        rsp_paddr = paddr_q;
    end

endmodule

// File: rtl/pxu_checker.sv
// Temporal checks for page_xlate_unit, attached by bind below.
module pxu_checker #(
    parameter int LA_W    = 16,
    parameter int OFS_W   = 10,
    parameter int FRAME_W = 8,
    parameter int MEM_AW  = 16,
    localparam int PN_W   = LA_W - OFS_W,
    localparam int LEN_W  = PN_W + 1,
    localparam int PA_W   = FRAME_W + OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LA_W-1:0]   req_laddr,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [1:0]        rsp_fault,
    input logic              mem_req,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_ack,
    input logic              base_we,
    input logic              len_we,
    input logic [MEM_AW-1:0] base_q,
    input logic [LEN_W-1:0]  len_q
);

    logic [PN_W-1:0] pg;
    logic            in_range;
    logic            take;

    // Page of the presented request and its bound status.
    always_comb begin
        pg       = req_laddr[LA_W-1:OFS_W];
        in_range = ({1'b0, pg} < len_q);
        take     = req_valid && req_ready;
    end

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req) |-> !req_ready);

    p_bound_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_range) |=> (rsp_valid && rsp_fault == 2'b01 && !mem_req));

    p_walk_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_range) |=> (mem_req && mem_addr == $past(base_q + MEM_AW'(pg))));

    p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_read_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (rsp_valid && !mem_req));

    p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

    p_len_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && len_we) |=> $stable(len_q));

    p_base_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && base_we) |=> $stable(base_q));

endmodule

bind page_xlate_unit pxu_checker #(
    .LA_W    (LA_W),
    .OFS_W   (OFS_W),
    .FRAME_W (FRAME_W),
    .MEM_AW  (MEM_AW)
) i_pxu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_laddr (req_laddr),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .base_we   (base_we),
    .len_we    (len_we),
    .base_q    (base_q),
    .len_q     (len_q)
);

// File: tb/test_page_xlate_unit.sv
`timescale 1ns/1ps
module test_page_xlate_unit;

    localparam int LA_W = 4, OFS_W = 2, FRAME_W = 2, MEM_AW = 4;
    localparam int PA_W = FRAME_W + OFS_W, ENT_W = FRAME_W + 3, LEN_W = LA_W - OFS_W + 1;

    // Vector: {laddr[3:0], kind[1:0], exp_fault[1:0], exp_paddr[3:0]}
    // Table at base 4, length 3.
    localparam logic [11:0] VEC [9] = '{
        {4'b0010, 2'b00, 2'b00, 4'b1110},  // R1 example one
        {4'b0101, 2'b00, 2'b00, 4'b0101},  // R1 example two
        {4'b0111, 2'b01, 2'b11, 4'b0000},  // R5 write to read-only
        {4'b0001, 2'b01, 2'b00, 4'b1101},  // R5 write to read-write
        {4'b0000, 2'b10, 2'b11, 4'b0000},  // R5 fetch from read-write
        {4'b1001, 2'b00, 2'b10, 4'b0000},  // R4 absent entry
        {4'b1011, 2'b10, 2'b10, 4'b0000},  // R4 absent beats rights
        {4'b1100, 2'b00, 2'b01, 4'b0000},  // R3 page equals length
        {4'b0011, 2'b11, 2'b11, 4'b0000}   // R5 reserved kind
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [LA_W-1:0] req_laddr = '0;
    logic [1:0] req_kind = '0;
    logic rsp_valid;
    logic [PA_W-1:0] rsp_paddr;
    logic [1:0] rsp_fault;
    logic mem_req;
    logic [MEM_AW-1:0] mem_addr;
    logic mem_ack;
    logic [ENT_W-1:0] mem_rdata;
    logic base_we = 1'b0;
    logic [MEM_AW-1:0] base_wdata = '0;
    logic len_we = 1'b0;
    logic [LEN_W-1:0] len_wdata = '0;

    logic [ENT_W-1:0] mem [16];
    int rd_cnt;
    logic [MEM_AW-1:0] last_addr;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    page_xlate_unit #(
        .LA_W (LA_W), .OFS_W (OFS_W), .FRAME_W (FRAME_W), .MEM_AW (MEM_AW)
    ) i_page_xlate_unit (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_laddr (req_laddr), .req_kind (req_kind),
        .rsp_valid (rsp_valid), .rsp_paddr (rsp_paddr), .rsp_fault (rsp_fault),
        .mem_req (mem_req), .mem_addr (mem_addr),
        .mem_ack (mem_ack), .mem_rdata (mem_rdata),
        .base_we (base_we), .base_wdata (base_wdata),
        .len_we (len_we), .len_wdata (len_wdata)
    );

    // Table memory: acknowledges one negedge after a request, counts reads.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            rd_cnt <= 0;
            mem_rdata <= '0;
            last_addr <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            rd_cnt <= rd_cnt + 1;
        end else if (mem_req) begin
            mem_ack <= 1'b1;
            mem_rdata <= mem[mem_addr];
            last_addr <= mem_addr;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [MEM_AW-1:0] b, input logic [LEN_W-1:0] l);
        @(negedge clk);
        base_we = 1'b1; base_wdata = b;
        len_we = 1'b1; len_wdata = l;
        @(negedge clk);
        base_we = 1'b0; len_we = 1'b0;
    endtask

    // One translation; returns response fields, read count and last read address.
    task automatic xlate(input logic [3:0] a, input logic [1:0] k,
                         output logic [1:0] f, output logic [3:0] p,
                         output int reads, output logic [MEM_AW-1:0] ma);
        int c0;
        int n;
        c0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_laddr = a; req_kind = k;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 ready low while busy", int'(req_ready), 0);
        n = 0;
        while (!rsp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        f = rsp_fault;
        p = rsp_paddr;
        @(negedge clk);
        check("R6 response one cycle", int'(rsp_valid), 0);
        reads = rd_cnt - c0;
        ma = last_addr;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL R6 watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [1:0] f;
        logic [3:0] p;
        int rd;
        logic [MEM_AW-1:0] ma;

        for (int i = 0; i < 16; i++) mem[i] = '0;
        // R10 entries {rights, present, frame}
        mem[4]  = 5'b01_1_11;  // page0 frame3 read-write
        mem[5]  = 5'b00_1_01;  // page1 frame1 read-only
        mem[6]  = 5'b01_0_10;  // page2 absent
        mem[7]  = 5'b10_1_00;  // page3 frame0 execute-only
        mem[8]  = 5'b01_1_10;  // second table page0 frame2 read-write
        mem[9]  = 5'b11_1_01;  // second table page1 rights none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ready after reset", int'(req_ready), 1);
        check("R9 no response after reset", int'(rsp_valid), 0);
        check("R9 no read after reset", int'(mem_req), 0);
        xlate(4'b0010, 2'b00, f, p, rd, ma);
        check("R9 zero length bounds fault", int'(f), 1);
        check("R9 no read with zero length", rd, 0);

        set_cfg(4'd4, 3'd3);
        foreach (VEC[i]) begin
            xlate(VEC[i][11:8], VEC[i][7:6], f, p, rd, ma);
            check("R1 R3 R4 R5 fault code", int'(f), int'(VEC[i][5:4]));
            check("R1 R8 physical address", int'(p), int'(VEC[i][3:0]));
            check("R2 R3 read count", rd, (VEC[i][5:4] == 2'b01) ? 0 : 1);
            if (VEC[i][5:4] != 2'b01)
                check("R2 entry address", int'(ma), 4 + int'(VEC[i][11:10]));
        end

        // R7 length write while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_laddr = 4'b0010; req_kind = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        len_we = 1'b1; len_wdata = 3'd0;
        base_we = 1'b1; base_wdata = 4'd8;
        @(negedge clk);
        len_we = 1'b0; base_we = 1'b0;
        repeat (3) @(negedge clk);
        xlate(4'b0001, 2'b01, f, p, rd, ma);
        check("R7 busy length write ignored", int'(f), 0);
        check("R7 busy base write ignored", int'(ma), 4);

        // R3 full length makes page 3 reachable, R5 execute-only
        set_cfg(4'd4, 3'd4);
        xlate(4'b1110, 2'b10, f, p, rd, ma);
        check("R5 fetch from execute-only", int'(f), 0);
        check("R1 execute-only address", int'(p), 4'b0010);
        xlate(4'b1101, 2'b00, f, p, rd, ma);
        check("R5 read from execute-only", int'(f), 3);

        // R2 R7 new base used by next request
        set_cfg(4'd8, 3'd2);
        xlate(4'b0011, 2'b00, f, p, rd, ma);
        check("R2 second table address", int'(ma), 8);
        check("R1 second table translation", int'(p), 4'b1011);
        xlate(4'b0100, 2'b00, f, p, rd, ma);
        check("R5 rights code 11 denies", int'(f), 3);
        check("R8 zero address on fault", int'(p), 0);

        // R7 idle length write takes effect
        set_cfg(4'd8, 3'd0);
        xlate(4'b0000, 2'b00, f, p, rd, ma);
        check("R7 idle length write used", int'(f), 1);
        check("R3 no read on bound fault", rd, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule